// File: doc/BRIEF.md
# Offset-Corrected Difference Gain Stage

This block builds the feedback error signal of a beam damper from two pickup channels. Each signed converter sample is scaled by its own programmable offset coefficient. The scaled bottom value is subtracted from the scaled top value, and the difference is multiplied by a programmable loop gain. The offset coefficients are set so that the difference is close to zero while the beam sits on its stable closed orbit. The gain then sets how hard the loop pushes back. The 16-bit signed result feeds the programmable delay stage that follows.

Both channels share one valid strobe. The arithmetic is fixed point: coefficients are signed Q2.15, every product is rounded to nearest before the next stage, and the final value saturates to 16 bits. The pipeline is four register stages deep. A coefficient write can land while samples are streaming. Each sample takes the coefficient set that is active in the cycle it enters, and the gain travels down the pipe with the sample. A per-sample bypass input skips the scaling and passes the plain channel difference through with the same latency.

Top module: `orbit_diff_gain`

## Requirements
- R1: After reset, outValid is 0 and outData is 0. The active coefficients are top = bottom = gain = 1.0 (code 32768 in Q2.15), and bypass is off.
- R2: Each channel product v*M (14-bit signed sample, 18-bit signed Q2.15 coefficient) is rounded to the integer floor((v*M + 16384) / 32768), so ties round toward plus infinity.
- R3: With bypass off, outData = sat16(floor((D*G + 16384) / 32768)), where D is the rounded top product minus the rounded bottom product and G is the Q2.15 gain.
- R4: A result above 32767 is output as 32767, and a result below -32768 is output as -32768. The value never wraps.
- R5: outValid is high in cycle c+4 exactly when inValid was high in cycle c. Each result belongs to the sample that entered four cycles earlier.
- R6: coefWrEn loads coefTop, coefBot and coefGain together. A sample that enters in the same cycle as the write uses the previous set. Every later sample uses the new set, and no output mixes the two sets.
- R7: When bypassEn is high in the cycle a sample enters, its result is inTop minus inBot, sign-extended to 16 bits. The coefficients are ignored, and the latency is the same four cycles.
- R8: In any cycle with outValid low, outData keeps the last value that was output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Both channel samples are valid this cycle |
| inTop | input | 14 | Top pickup sample, signed |
| inBot | input | 14 | Bottom pickup sample, signed |
| bypassEn | input | 1 | Pass the raw channel difference for this sample |
| coefWrEn | input | 1 | Load a new coefficient set |
| coefTop | input | 18 | Top channel offset coefficient, signed Q2.15 |
| coefBot | input | 18 | Bottom channel offset coefficient, signed Q2.15 |
| coefGain | input | 18 | Loop gain, signed Q2.15 |
| outValid | output | 1 | outData carries a new result |
| outData | output | 16 | Saturated error signal, signed |

## Verification
A coefficient update and a streaming sample can arrive in the same cycle. The gain is applied two stages after the offsets, so this is where old and new coefficients could mix in one result. The bench keeps inValid high without a gap and raises coefWrEn together with the first sample of each new coefficient set. The expected value for that sample is computed from the previous set, and from the next sample onward it is computed from the new set. Bypass is also toggled on alternate samples inside the same stream, so that a bypassed result and a scaled result leave the pipe in neighbouring cycles.

// File: rtl/odg_pkg.sv
package odg_pkg;
  // Stage load strobes issued by the control to the datapath.
  typedef struct packed {
    logic ld1;  // sample enters: scale both channels
    logic ld2;  // subtract scaled channels
    logic ld3;  // apply gain and round
    logic ld4;  // saturate / select bypass, update output
  } odg_strobe_t;
endpackage

// File: rtl/odg_ctrl.sv
module odg_ctrl
  import odg_pkg::*;
#(
  parameter int COEF_W = 18,
  parameter int FRAC   = 15
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     coefWrEn,
  input  logic signed [COEF_W-1:0] coefTop,
  input  logic signed [COEF_W-1:0] coefBot,
  input  logic signed [COEF_W-1:0] coefGain,
  output odg_strobe_t              strb,
  output logic                     outValid,
  output logic signed [COEF_W-1:0] actTop,
  output logic signed [COEF_W-1:0] actBot,
  output logic signed [COEF_W-1:0] actGain
);
  localparam int STAGES = 4;
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1) <<< FRAC;

  logic [STAGES-1:0] vldPipe;

  // Valid travels one stage per clock; each bit enables the next stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strb.ld1 = inValid;
    strb.ld2 = vldPipe[0];
    strb.ld3 = vldPipe[1];
    strb.ld4 = vldPipe[2];
  end

  assign outValid = vldPipe[STAGES-1];

  // Active set: a write is seen by samples entering after the write edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actTop  <= UNITY;
      actBot  <= UNITY;
      actGain <= UNITY;
    end else if (coefWrEn) begin
      actTop  <= coefTop;
      actBot  <= coefBot;
      actGain <= coefGain;
    end
  end
endmodule

// File: rtl/odg_datapath.sv
module odg_datapath
  import odg_pkg::*;
#(
  parameter int IN_W   = 14,
  parameter int COEF_W = 18,
  parameter int FRAC   = 15,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  odg_strobe_t              strb,
  input  logic signed [IN_W-1:0]   inTop,
  input  logic signed [IN_W-1:0]   inBot,
  input  logic                     bypassEn,
  input  logic signed [COEF_W-1:0] mTop,
  input  logic signed [COEF_W-1:0] mBot,
  input  logic signed [COEF_W-1:0] gain,
  output logic signed [OUT_W-1:0]  outData
);
  localparam int PW  = IN_W + COEF_W;   // channel product
  localparam int SW  = PW - FRAC;       // rounded scaled channel
  localparam int DW  = SW + 1;          // scaled difference
  localparam int GPW = DW + COEF_W;     // gain product
  localparam int GW  = GPW - FRAC;      // rounded gain result
  localparam int BW  = IN_W + 1;        // raw difference
  localparam int HW  = GW - OUT_W + 1;  // bits that must agree for no overflow
  localparam logic signed [PW-1:0]    RND_P  = PW'(1) <<< (FRAC - 1);
  localparam logic signed [GPW-1:0]   RND_G  = GPW'(1) <<< (FRAC - 1);
  localparam logic signed [OUT_W-1:0] OUTMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OUTMIN = {1'b1, {(OUT_W-1){1'b0}}};

  // Stage 1: scale each channel, round to nearest
  logic signed [PW-1:0] prodTop, prodBot, sumTop, sumBot;
  logic signed [BW-1:0] rawDiff;
  logic signed [SW-1:0] scTopS1, scBotS1;
  logic signed [BW-1:0] rawS1;
  logic signed [COEF_W-1:0] gainS1;
  logic                 bypS1;

  always_comb begin
    prodTop = {{(PW-IN_W){inTop[IN_W-1]}}, inTop} * {{(PW-COEF_W){mTop[COEF_W-1]}}, mTop};
    prodBot = {{(PW-IN_W){inBot[IN_W-1]}}, inBot} * {{(PW-COEF_W){mBot[COEF_W-1]}}, mBot};
    sumTop  = prodTop + RND_P;
    sumBot  = prodBot + RND_P;
    rawDiff = {inTop[IN_W-1], inTop} - {inBot[IN_W-1], inBot};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scTopS1 <= '0; scBotS1 <= '0; rawS1 <= '0; gainS1 <= '0; bypS1 <= 1'b0;
    end else if (strb.ld1) begin
      scTopS1 <= sumTop[PW-1:FRAC];
      scBotS1 <= sumBot[PW-1:FRAC];
      rawS1   <= rawDiff;
      gainS1  <= gain;       // gain snapshot travels with the sample
      bypS1   <= bypassEn;
    end
  end

  // Stage 2: subtract scaled channels
  logic signed [DW-1:0]     diffS2;
  logic signed [BW-1:0]     rawS2;
  logic signed [COEF_W-1:0] gainS2;
  logic                     bypS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      diffS2 <= '0; rawS2 <= '0; gainS2 <= '0; bypS2 <= 1'b0;
    end else if (strb.ld2) begin
      diffS2 <= {scTopS1[SW-1], scTopS1} - {scBotS1[SW-1], scBotS1};
      rawS2  <= rawS1;
      gainS2 <= gainS1;
      bypS2  <= bypS1;
    end
  end

  // Stage 3: apply loop gain, round to nearest
  logic signed [GPW-1:0] gProd, gSum;
  logic signed [GW-1:0]  gainedS3;
  logic signed [BW-1:0]  rawS3;
  logic                  bypS3;

  always_comb begin
    gProd = {{(GPW-DW){diffS2[DW-1]}}, diffS2} * {{(GPW-COEF_W){gainS2[COEF_W-1]}}, gainS2};
    gSum  = gProd + RND_G;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainedS3 <= '0; rawS3 <= '0; bypS3 <= 1'b0;
    end else if (strb.ld3) begin
      gainedS3 <= gSum[GPW-1:FRAC];
      rawS3    <= rawS2;
      bypS3    <= bypS2;
    end
  end

  // Stage 4: saturate or pass the raw difference
  logic [HW-1:0]           hiBits;
  logic signed [OUT_W-1:0] satVal, nextOut;

  always_comb begin
    hiBits = gainedS3[GW-1:OUT_W-1];
    if ((&hiBits) || !(|hiBits)) satVal = gainedS3[OUT_W-1:0];
    else if (gainedS3[GW-1])     satVal = OUTMIN;
    else                         satVal = OUTMAX;
    nextOut = bypS3 ? {{(OUT_W-BW){rawS3[BW-1]}}, rawS3} : satVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          outData <= '0;
    else if (strb.ld4)  outData <= nextOut;
  end
endmodule

// File: rtl/orbit_diff_gain.sv
module orbit_diff_gain
  import odg_pkg::*;
#(
  parameter int IN_W   = 14,
  parameter int COEF_W = 18,
  parameter int FRAC   = 15,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [IN_W-1:0]   inTop,
  input  logic signed [IN_W-1:0]   inBot,
  input  logic                     bypassEn,
  input  logic                     coefWrEn,
  input  logic signed [COEF_W-1:0] coefTop,
  input  logic signed [COEF_W-1:0] coefBot,
  input  logic signed [COEF_W-1:0] coefGain,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outData
);
  odg_strobe_t              strb;
  logic signed [COEF_W-1:0] actTop, actBot, actGain;

  odg_ctrl #(.COEF_W(COEF_W), .FRAC(FRAC)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .coefWrEn(coefWrEn),
    .coefTop(coefTop), .coefBot(coefBot), .coefGain(coefGain),
    .strb(strb), .outValid(outValid),
    .actTop(actTop), .actBot(actBot), .actGain(actGain)
  );

  odg_datapath #(.IN_W(IN_W), .COEF_W(COEF_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inTop(inTop), .inBot(inBot), .bypassEn(bypassEn),
    .mTop(actTop), .mBot(actBot), .gain(actGain),
    .outData(outData)
  );
endmodule

// File: rtl/odg_checker.sv
module odg_checker #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic signed [IN_W-1:0]  inTop,
  input logic signed [IN_W-1:0]  inBot,
  input logic                    bypassEn,
  input logic                    outValid,
  input logic signed [OUT_W-1:0] outData
);
  logic [2:0] warm;
  logic signed [OUT_W-1:0] rawExp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         warm <= '0;
    else if (warm < 4) warm <= warm + 3'd1;
  end

  assign rawExp = OUT_W'(inTop) - OUT_W'(inBot);

  // R5: valid leaves exactly four cycles after it entered
  p_valid_latency_r5: assert property (@(posedge clk) disable iff (!rstN || warm < 4)
    outValid == $past(inValid, 4));

  // R8: output held while no result leaves
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN || warm < 1)
    !outValid |-> $stable(outData));

  // R7: bypassed sample yields the raw difference
  p_bypass_diff_r7: assert property (@(posedge clk) disable iff (!rstN || warm < 4)
    (outValid && $past(inValid, 4) && $past(bypassEn, 4)) |-> outData == $past(rawExp, 4));

  // R3: zero on both channels gives zero for any coefficients
  p_zero_in_r3: assert property (@(posedge clk) disable iff (!rstN || warm < 4)
    (outValid && $past(inValid, 4) && $past(inTop, 4) == 0 && $past(inBot, 4) == 0) |-> outData == 0);
endmodule

bind orbit_diff_gain odg_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inTop(inTop), .inBot(inBot),
  .bypassEn(bypassEn), .outValid(outValid), .outData(outData)
);

// File: tb/tb_orbit_diff_gain.sv
`timescale 1ns/1ps
module tb_orbit_diff_gain;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, bypassEn = 1'b0, coefWrEn = 1'b0;
  logic signed [13:0] inTop = '0, inBot = '0;
  logic signed [17:0] coefTop = '0, coefBot = '0, coefGain = '0;
  logic outValid;
  logic signed [15:0] outData;

  int tests = 0, fails = 0;
  longint cyc = 0;
  bit done = 0;

  longint expQ[$];
  longint entQ[$];
  string  tagQ[$];

  orbit_diff_gain dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTop(inTop), .inBot(inBot),
    .bypassEn(bypassEn), .coefWrEn(coefWrEn), .coefTop(coefTop), .coefBot(coefBot),
    .coefGain(coefGain), .outValid(outValid), .outData(outData)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint rnd15(longint p);
    return (p + 16384) >>> 15;
  endfunction

  function automatic longint sat16(longint x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Model state: coefficients active for the next entering sample
  longint mT = 32768, mB = 32768, mG = 32768;

  task automatic send(int vt, int vb, bit byp, string tag);
    longint e;
    @(negedge clk);
    inValid = 1; inTop = 14'(vt); inBot = 14'(vb); bypassEn = byp;
    if (byp) e = vt - vb;
    else     e = sat16(rnd15((rnd15(vt * mT) - rnd15(vb * mB)) * mG));
    if (!byp && (e == 32767 || e == -32768)) tag = "R4";
    expQ.push_back(e); entQ.push_back(cyc); tagQ.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 0; coefWrEn = 0; bypassEn = 0;
  endtask

  // Monitor: values and timing of every result, hold on idle cycles
  longint prevOut = 0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) check("R5", 1, 0);
        else begin
          longint e, en; string t;
          e = expQ.pop_front(); en = entQ.pop_front(); t = tagQ.pop_front();
          check(t, outData, e);
          check("R5", cyc - en, 4);
        end
      end else begin
        check("R8", outData, prevOut);
      end
      prevOut = outData;
    end
  end

  function automatic int vval(int i);
    int v;
    v = -8192 + i * 1024 + (i % 3);
    if (v > 8191) v = 8191;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", outValid, 0);
    check("R1", outData, 0);
    rstN = 1;
    @(negedge clk);
    check("R1", outValid, 0);

    // R1 default unity coefficients, R3 base function
    for (int a = 0; a < 17; a++)
      for (int b = 0; b < 17; b++)
        send(vval(a), vval(b), 0, "R1");

    // Coefficient sets written mid-stream (R6), with bypass interleaved (R7)
    for (int s = 0; s < 5; s++) begin
      longint nT, nB, nG; string tg;
      case (s)
        0: begin nT = 16384;   nB = 16384;  nG = 32768;   tg = "R2"; end
        1: begin nT = -131072; nB = 131071; nG = 131071;  tg = "R4"; end
        2: begin nT = 12345;   nB = -23456; nG = 40000;   tg = "R3"; end
        3: begin nT = 32768;   nB = 32768;  nG = 3277;    tg = "R3"; end
        default: begin nT = -50000; nB = 70000; nG = -131072; tg = "R3"; end
      endcase
      for (int a = 0; a < 17; a++)
        for (int b = 0; b < 17; b++) begin
          bit byp;
          byp = (s == 2) && ((a + b) % 2 == 1);
          if (a == 0 && b == 0) begin
            // R6: write lands in the same cycle as a streaming sample
            send(vval(a), vval(b), byp, "R6");
            coefWrEn = 1; coefTop = 18'(nT); coefBot = 18'(nB); coefGain = 18'(nG);
            mT = nT; mB = nB; mG = nG;
          end else begin
            send(vval(a), vval(b), byp, byp ? "R7" : ((a == 0 && b == 1) ? "R6" : tg));
            coefWrEn = 0;
          end
          if ((a * 17 + b) % 37 == 36) begin
            idle(); idle();   // R8 gaps
          end
        end
    end

    // R2: odd inputs at 0.5 scale (ties round up)
    coefWrEn = 0;
    @(negedge clk);
    coefWrEn = 1; coefTop = 18'sd16384; coefBot = 18'sd0; coefGain = 18'sd32768;
    inValid = 0;
    mT = 16384; mB = 0; mG = 32768;
    for (int v = -7; v <= 7; v += 2) begin
      send(v, 0, 0, "R2");
      coefWrEn = 0;
    end

    idle();
    repeat (8) @(negedge clk);
    check("R5", expQ.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule